// File: doc/BRIEF.md
# Missed-Tick Recovery Scheduler

This block is run once each time a periodic timer interrupt is serviced. Software hands it the free-running counter value read at service time, the stored boundary at which the interrupt was meant to fire, the tick period in counter cycles and the number of ticks per second. The block works out how many whole ticks have gone by since the intended boundary. It returns the new intended boundary, which stays on the original period grid however late the service was, and the value to load into the compare register. When the new boundary lies too close to the present counter value to be reached safely, the compare value is moved one further period out. A late flag marks a service delay of more than one second's worth of ticks.

The work is split by how late the service is. A slightly late service takes a short loop of repeated subtraction, one period per cycle. A very late service takes a sequential restoring divide. A start pulse with the inputs begins one operation, and a one-cycle done pulse marks the cycle in which the results become valid. An initialisation mode sets up the first boundary one period after the counter value that is supplied.

The period is normally chosen as 100 times the counter cycles per 10 ms, divided by the tick rate.

Top module: `tick_catchup`

## Requirements
- R1: The elapsed count is `nowCnt - nextTickIn`, taken as unsigned modulo 2^W. A counter that has wrapped past zero therefore still gives the short positive distance.
- R2: If `(elapsed >> 5) < period`, the result comes from repeated subtraction. It starts with ticks = 1 and remainder = elapsed. While remainder > period (strictly greater), one period is taken off and ticks goes up by one. A remainder equal to the period therefore stays as it is, which gives zero cycles to the boundary.
- R3: Otherwise, remainder = elapsed mod period and ticks = 1 + elapsed / period.
- R4: `lateFlag` is 1 exactly when ticks > `tickRate`. When ticks equals the rate, it is 0.
- R5: The cycles to the boundary equal period minus remainder, and `nextTickOut` = `nowCnt` + that value.
- R6: When the cycles to the boundary are below 8192 (bits 13 and above all zero), `compareOut` = `nextTickOut` + period. Otherwise `compareOut` = `nextTickOut`.
- R7: With `initMode` = 1, `nextTickOut` = `compareOut` = `nowCnt` + period, `ticksOut` = 0 and `lateFlag` = 0.
- R8: A zero period gives `periodErr` = 1, `ticksOut` = 0 and `lateFlag` = 0, and leaves `nextTickOut` and `compareOut` at their previous values. Any operation with a nonzero period clears `periodErr`.
- R9: Each accepted start gives exactly one `done` pulse, one cycle wide. The outputs are valid in that cycle and hold until the next operation completes.
- R10: After reset, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one operation; the data inputs are sampled with it |
| initMode | input | 1 | 1 = set the first boundary, 0 = service an interrupt |
| nowCnt | input | W | Counter value read at service time |
| nextTickIn | input | W | Stored intended boundary |
| period | input | W | Tick period in cycles |
| tickRate | input | W | Ticks per second |
| done | output | 1 | One-cycle result-valid pulse |
| ticksOut | output | W | Ticks elapsed |
| nextTickOut | output | W | New intended boundary, to be stored |
| compareOut | output | W | Value for the compare register |
| lateFlag | output | 1 | More than one second of ticks elapsed |
| periodErr | output | 1 | Period was zero |

## Verification
The late warning and the one-period skip can both come out of the same operation. This happens when a service is more than a second late and its remainder also leaves a boundary within 8192 cycles. The bench provokes this with a short period and an elapsed count just past the rate's worth of periods, and judges the case by checking `lateFlag` and the extended `compareOut` against a reference computed in the bench. A second pairing is tested as well: an elapsed count that is an exact multiple of the period on the subtraction path. That case gives zero cycles to the boundary together with the skip.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef struct packed {
    logic load;
    logic subStep;
    logic divStep;
    logic finish;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_SUB,
    ST_DIV,
    ST_FIN
  } ctlState_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       zeroPer,
  input  logic       initOp,
  input  logic       useSub,
  input  logic       subMore,
  input  logic       divLast,
  output ctlStrobe_t strb,
  output logic       done
);
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (zeroPer || initOp) stateNext = ST_FIN;
        else if (useSub)       stateNext = ST_SUB;
        else                   stateNext = ST_DIV;
      end
      ST_SUB: begin
        if (subMore) strb.subStep = 1'b1;
        else         stateNext = ST_FIN;
      end
      ST_DIV: begin
        strb.divStep = 1'b1;
        if (divLast) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.finish;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.subStep, strb.divStep, strb.finish}));
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int W = 32,
  parameter int SKIP_BITS = 13,
  parameter int SUB_SHIFT = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   strb,
  input  logic         initIn,
  input  logic [W-1:0] nowIn,
  input  logic [W-1:0] nextIn,
  input  logic [W-1:0] perIn,
  input  logic [W-1:0] rateIn,
  output logic         zeroPer,
  output logic         initOp,
  output logic         useSub,
  output logic         subMore,
  output logic         divLast,
  output logic [W-1:0] ticksOut,
  output logic [W-1:0] nextOut,
  output logic [W-1:0] cmpOut,
  output logic         lateOut,
  output logic         errOut
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  nowR, perR, rateR, elapsedR, remR, ticksR, qReg;
  logic [W:0]    pRem;
  logic [CW-1:0] bitCnt;
  logic          initR;

  logic [W:0]    shifted, trial;
  logic          fit;
  logic [W-1:0]  remSel, tickSel, toBoundary, nextCalc, cmpCalc;

  assign zeroPer = (perR == '0);
  assign initOp  = initR;
  assign useSub  = (elapsedR >> SUB_SHIFT) < perR;
  assign subMore = remR > perR;
  assign divLast = (bitCnt == CW'(W - 1));

  assign shifted = {pRem[W-1:0], qReg[W-1]};
  assign fit     = shifted >= {1'b0, perR};
  assign trial   = shifted - {1'b0, perR};

  assign remSel     = useSub ? remR : pRem[W-1:0];
  assign tickSel    = useSub ? ticksR : qReg + W'(1);
  assign toBoundary = perR - remSel;
  assign nextCalc   = nowR + toBoundary;
  assign cmpCalc    = ((toBoundary >> SKIP_BITS) == '0) ? nextCalc + perR : nextCalc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowR <= '0; perR <= '0; rateR <= '0; elapsedR <= '0; initR <= 1'b0;
      remR <= '0; ticksR <= '0; qReg <= '0; pRem <= '0; bitCnt <= '0;
      ticksOut <= '0; nextOut <= '0; cmpOut <= '0; lateOut <= 1'b0; errOut <= 1'b0;
    end else begin
      if (strb.load) begin
        nowR     <= nowIn;
        perR     <= perIn;
        rateR    <= rateIn;
        initR    <= initIn;
        elapsedR <= nowIn - nextIn;
        remR     <= nowIn - nextIn;
        qReg     <= nowIn - nextIn;
        ticksR   <= W'(1);
        pRem     <= '0;
        bitCnt   <= '0;
      end
      if (strb.subStep) begin
        remR   <= remR - perR;
        ticksR <= ticksR + W'(1);
      end
      if (strb.divStep) begin
        pRem   <= fit ? trial : shifted;
        qReg   <= {qReg[W-2:0], fit};
        bitCnt <= bitCnt + CW'(1);
      end
      if (strb.finish) begin
        if (zeroPer) begin
          errOut   <= 1'b1;
          ticksOut <= '0;
          lateOut  <= 1'b0;
        end else if (initR) begin
          errOut   <= 1'b0;
          ticksOut <= '0;
          lateOut  <= 1'b0;
          nextOut  <= nowR + perR;
          cmpOut   <= nowR + perR;
        end else begin
          errOut   <= 1'b0;
          ticksOut <= tickSel;
          lateOut  <= tickSel > rateR;
          nextOut  <= nextCalc;
          cmpOut   <= cmpCalc;
        end
      end
    end
  end

  assert_sub_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.subStep |=> (ticksR == $past(ticksR) + W'(1)) && (remR < $past(remR)));
  assert_div_rem_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.divStep |=> pRem < {1'b0, perR});
  assert_cmp_grid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !zeroPer) |=> (cmpOut == nextOut) || (cmpOut == nextOut + perR));
  assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && zeroPer) |=> errOut && (ticksOut == '0) && $stable(nextOut));
endmodule

// File: rtl/tick_catchup.sv
module tick_catchup
  import tick_pkg::*;
#(
  parameter int W = 32,
  parameter int SKIP_BITS = 13,
  parameter int SUB_SHIFT = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         initMode,
  input  logic [W-1:0] nowCnt,
  input  logic [W-1:0] nextTickIn,
  input  logic [W-1:0] period,
  input  logic [W-1:0] tickRate,
  output logic         done,
  output logic [W-1:0] ticksOut,
  output logic [W-1:0] nextTickOut,
  output logic [W-1:0] compareOut,
  output logic         lateFlag,
  output logic         periodErr
);
  ctlStrobe_t strb;
  logic zeroPer, initOp, useSub, subMore, divLast;

  tick_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .zeroPer(zeroPer), .initOp(initOp), .useSub(useSub),
    .subMore(subMore), .divLast(divLast),
    .strb(strb), .done(done)
  );

  tick_datapath #(.W(W), .SKIP_BITS(SKIP_BITS), .SUB_SHIFT(SUB_SHIFT)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .initIn(initMode),
    .nowIn(nowCnt), .nextIn(nextTickIn), .perIn(period), .rateIn(tickRate),
    .zeroPer(zeroPer), .initOp(initOp), .useSub(useSub),
    .subMore(subMore), .divLast(divLast),
    .ticksOut(ticksOut), .nextOut(nextTickOut), .cmpOut(compareOut),
    .lateOut(lateFlag), .errOut(periodErr)
  );
endmodule

// File: tb/test_tick_catchup.sv
module test_tick_catchup;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic initMode = 1'b0;
  logic [W-1:0] nowCnt = '0, nextTickIn = '0, period = '0, tickRate = '0;
  logic done, lateFlag, periodErr;
  logic [W-1:0] ticksOut, nextTickOut, compareOut;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] lastNext = '0, lastCmp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_catchup i_tick_catchup (
    .clk(clk), .rstN(rstN), .start(start), .initMode(initMode),
    .nowCnt(nowCnt), .nextTickIn(nextTickIn), .period(period), .tickRate(tickRate),
    .done(done), .ticksOut(ticksOut), .nextTickOut(nextTickOut),
    .compareOut(compareOut), .lateFlag(lateFlag), .periodErr(periodErr)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one operation and compares against a bench-side reference.
  task automatic runOp(string req, logic ini, logic [W-1:0] now, logic [W-1:0] nxt,
                       logic [W-1:0] per, logic [W-1:0] rate);
    logic [W-1:0] el, rem, tk, ctb, eNext, eCmp;
    logic eLate, eErr;
    int wait_cnt;
    el = now - nxt;                             // R1
    eErr = (per == 0);
    if (eErr) begin                             // R8
      tk = 0; eLate = 0; eNext = lastNext; eCmp = lastCmp;
    end else if (ini) begin                     // R7
      tk = 0; eLate = 0; eNext = now + per; eCmp = eNext;
    end else begin
      if ((el >> 5) < per) begin                // R2
        rem = el; tk = 1;
        while (rem > per) begin rem = rem - per; tk = tk + 1; end
      end else begin                            // R3
        rem = el % per; tk = 1 + el / per;
      end
      eLate = tk > rate;                        // R4
      ctb = per - rem;                          // R5
      eNext = now + ctb;
      eCmp = ((ctb >> 13) == 0) ? eNext + per : eNext;  // R6
    end
    @(negedge clk);
    initMode = ini; nowCnt = now; nextTickIn = nxt; period = per; tickRate = rate;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cnt = 0;
    while (!done && wait_cnt < 200) begin @(negedge clk); wait_cnt++; end
    checks++;
    if (!done) begin
      fails++;
      $display("FAIL R9 %s watchdog: actual done=0 expected done=1", req);
      return;
    end
    check(req, "ticks", ticksOut, tk);
    check(req, "next", nextTickOut, eNext);
    check(req, "compare", compareOut, eCmp);
    check(req, "late", W'(lateFlag), W'(eLate));
    check(req, "err", W'(periodErr), W'(eErr));
    @(negedge clk);
    check("R9", "done width", W'(done), '0);
    check("R9", "hold next", nextTickOut, eNext);
    lastNext = eNext; lastCmp = eCmp;
  endtask

  task automatic testReset();
    check("R10", "done", W'(done), '0);
    check("R10", "ticks", ticksOut, '0);
    check("R10", "next", nextTickOut, '0);
    check("R10", "compare", compareOut, '0);
    check("R10", "late/err", W'({lateFlag, periodErr}), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runOp("R7 init", 1, 32'd1000, 32'd0, 32'd500, 32'd100);
    runOp("R5 on-time", 0, 32'd1000200, 32'd1000000, 32'd100000, 32'd100);
    runOp("R6 skip near", 0, 32'd1600, 32'd1500, 32'd500, 32'd100);
    runOp("R2 missed", 0, 32'd1350000, 32'd1000000, 32'd100000, 32'd100);
    runOp("R2 exact multiple", 0, 32'd1300000, 32'd1000000, 32'd100000, 32'd100);
    runOp("R3 divide late", 0, 32'd11000000, 32'd1000000, 32'd100000, 32'd100);
    runOp("R4 rate equal", 0, 32'd49010, 32'd0, 32'd1000, 32'd50);
    runOp("R4 late and skip", 0, 32'd50010, 32'd0, 32'd1000, 32'd50);
    runOp("R1 wrap", 0, 32'h0000_0100, 32'hFFFF_FF00, 32'd100000, 32'd100);
    runOp("R6 threshold 8192", 0, 32'd91808, 32'd0, 32'd100000, 32'd100);
    runOp("R6 threshold 8191", 0, 32'd91809, 32'd0, 32'd100000, 32'd100);
    runOp("R2 crossover sub", 0, 32'd31999, 32'd0, 32'd1000, 32'd100);
    runOp("R3 crossover div", 0, 32'd32000, 32'd0, 32'd1000, 32'd100);
    runOp("R8 zero period", 0, 32'd5000, 32'd0, 32'd0, 32'd100);
    runOp("R8 recover", 0, 32'd70000, 32'd0, 32'd30000, 32'd100);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL R9 global watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule